// File: doc/BRIEF.md
# Video Register Boot and Write-Lockout Unit

This block is the CPU-facing register front end of a memory-mapped video controller during the first frames after it comes up. It tells three start events apart: a cold power-on, a warm reset, and a power cycle short enough that the chip kept some charge. Each event loads its own set of starting values into the control, mask, scroll, video-address, sprite-address, read-buffer and status state.

After any event is released, a cycle counter runs on the CPU clock. Until it reaches a lockout limit, writes to the control, mask, scroll and video-address offsets are dropped. The status, sprite-address, sprite-data and data-port offsets and the sprite-DMA trigger work from the first clock. The same counter raises the vertical-blank status flag at the two early points where a running frame would reach it. A mode input chooses between the 60 Hz and 50 Hz timing sets.

The counter stops at the last count it needs, so it never wraps. The register file at offsets 0 to 7 keeps its usual side effects. A status read clears the vertical-blank flag and the shared two-write toggle. Data-port accesses step the video address by 1, or by 32 when control bit 2 is set.

Top module: `vid_boot_regs`

## Requirements
- R1: While `powerOn` is high (it has priority over the other events), the following are loaded: control 0, mask 0, scroll 0, video address 0, sprite address 0, toggle clear and vertical-blank flag clear. The read buffer gets a nonzero value from an 8-bit pseudo-random sequence.
- R2: While `warmReset` is high (and no other event is), the following are cleared: control, mask, scroll, toggle and read buffer. The video address, sprite address and vertical-blank flag keep their values.
- R3: While `quickCycle` is high (and `powerOn` is low), the following are loaded: status 0x80 (flag set), sprite address 0x2F, video address 0x0001, and zero for control, mask, scroll and read buffer. The toggle is cleared.
- R4: With `palMode` low, a write to offset 0, 1, 5 or 6 is dropped if fewer than 29658 clocks have elapsed since the event was released. It is accepted from 29658 clocks on.
- R5: With `palMode` high, the same four offsets stay locked until 33132 clocks have elapsed.
- R6: Writes to offsets 3, 4 and 7, reads of offsets 2 and 7, and the DMA trigger act from the first clock after release.
- R7: Offsets 5 and 6 share one toggle. For scroll, the first write fills bits 7:0 and the second fills bits 15:8. For the video address, the first write fills bits 15:8 and the second fills bits 7:0. A status read clears the toggle.
- R8: With `palMode` low, the vertical-blank flag (status bit 7) becomes 1 after the 27384th clock from release. It is set again after the 57165th clock.
- R9: With `palMode` high, the flag is set after the 25683rd and the 58931st clock.
- R10: A read of offset 2 returns the flag in bit 7 (other bits 0) and clears the flag.
- R11: Once the counter reaches its final count it holds there, and the flag is not set again until the next event.
- R12: A read of offset 7 returns the read buffer, then loads the buffer from `vramRData`. Reads and writes of offset 7 add 32 to the video address if control bit 2 is 1, and 1 otherwise. Reads of other offsets return 0, except offset 2.
- R13: A write to offset 3 loads the sprite address, and each write to offset 4 increments it.
- R14: A high `dmaTrig` outside an event gives a one-cycle `dmaStart` pulse on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| powerOn | input | 1 | Cold power-on event, synchronous, active high |
| warmReset | input | 1 | Warm reset event, synchronous, active high |
| quickCycle | input | 1 | Short power cycle event, synchronous, active high |
| palMode | input | 1 | 1 selects the 50 Hz thresholds |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 3 | Register offset 0 to 7 |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data, combinational on busAddr |
| vramRData | input | 8 | Video memory byte for the read buffer |
| dmaTrig | input | 1 | Sprite DMA request |
| dmaStart | output | 1 | One-cycle DMA start pulse |
| ctrlReg | output | 8 | Control register |
| maskReg | output | 8 | Mask register |
| scrollReg | output | 16 | Scroll value {Y, X} |
| vramAddr | output | 16 | Video address |
| sprAddr | output | 8 | Sprite memory address |

## Verification
A counter that is off by one shows at once. The accepted write at the lockout limit, or the flag rising on the exact expected clock, moves by one cycle. Both are probed on the last clock before each threshold and on the threshold itself. An event that selects the wrong initial set, or a toggle left half-written, shows on the very next register read or the next two-byte write. A counter that wraps would only show as a spurious third flag, so a stretch after the second flag is watched as well.

// File: rtl/vid_boot_pkg.sv
package vid_boot_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_WARM  = 2'd1,
    EV_QUICK = 2'd2,
    EV_POWER = 2'd3
  } initKind_e;

  typedef struct packed {
    initKind_e initKind;
    logic      wrCtrl;
    logic      wrMask;
    logic      wrScroll;
    logic      wrAddr;
    logic      wrSpr;
    logic      incSpr;
    logic      wrData;
    logic      rdData;
    logic      rdStatus;
    logic      setVbl;
    logic      dmaGo;
  } strobe_t;

  localparam int REG_STATUS = 2;
  localparam int REG_DATA   = 7;

endpackage

// File: rtl/vid_boot_lfsr.sv
module vid_boot_lfsr #(
  parameter logic [7:0] SEED = 8'hB7
) (
  input  logic       clk,
  output logic [7:0] value
);
  logic [7:0] state;
  logic [7:0] nextState;

  // Free-running, never reset: its content at power-on is arbitrary.
  // A zero state (the one lock-up value) is replaced by the seed.
  always_comb begin
    if (state == 8'h00) nextState = SEED;
    else nextState = {state[6:0], state[7] ^ state[5] ^ state[4] ^ state[3]};
  end

  always_ff @(posedge clk) state <= nextState;

  assign value = (state == 8'h00) ? SEED : state;
endmodule

// File: rtl/vid_boot_ctrl.sv
module vid_boot_ctrl
  import vid_boot_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NTSC_LOCK  = 29658,
  parameter int NTSC_VBL1  = 27384,
  parameter int NTSC_FRAME = 29781,
  parameter int PAL_LOCK   = 33132,
  parameter int PAL_VBL1   = 25683,
  parameter int PAL_FRAME  = 33248
) (
  input  logic       clk,
  input  logic       powerOn,
  input  logic       warmReset,
  input  logic       quickCycle,
  input  logic       palMode,
  input  logic       busSel,
  input  logic       busWrite,
  input  logic [2:0] busAddr,
  input  logic       dmaTrig,
  output strobe_t    stb,
  output logic       unlocked
);
  localparam int NTSC_VBL2 = NTSC_VBL1 + NTSC_FRAME;
  localparam int PAL_VBL2  = PAL_VBL1 + PAL_FRAME;
  localparam int MAX_A     = (NTSC_VBL2 > PAL_VBL2) ? NTSC_VBL2 : PAL_VBL2;
  localparam int MAX_B     = (NTSC_LOCK > PAL_LOCK) ? NTSC_LOCK : PAL_LOCK;
  localparam int CNT_MAX   = (MAX_A > MAX_B) ? MAX_A : MAX_B;

  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] N_LOCK   = CNT_W'(NTSC_LOCK);
  localparam logic [CNT_W-1:0] P_LOCK   = CNT_W'(PAL_LOCK);
  localparam logic [CNT_W-1:0] N_SET1   = CNT_W'(NTSC_VBL1 - 1);
  localparam logic [CNT_W-1:0] N_SET2   = CNT_W'(NTSC_VBL2 - 1);
  localparam logic [CNT_W-1:0] P_SET1   = CNT_W'(PAL_VBL1 - 1);
  localparam logic [CNT_W-1:0] P_SET2   = CNT_W'(PAL_VBL2 - 1);

  logic             anyEv;
  initKind_e        evKind;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lockLimit;
  logic [CNT_W-1:0] set1;
  logic [CNT_W-1:0] set2;
  logic             acc;
  logic             wr;
  logic             rd;

  // Event priority: cold power-on, then short power cycle, then warm reset.
  always_comb begin
    if (powerOn)         evKind = EV_POWER;
    else if (quickCycle) evKind = EV_QUICK;
    else if (warmReset)  evKind = EV_WARM;
    else                 evKind = EV_NONE;
  end
  assign anyEv = powerOn | quickCycle | warmReset;

  // Clocks since release; stops at the last threshold it must reach.
  always_ff @(posedge clk) begin
    if (anyEv)               cnt <= '0;
    else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

  assign lockLimit = palMode ? P_LOCK : N_LOCK;
  assign set1      = palMode ? P_SET1 : N_SET1;
  assign set2      = palMode ? P_SET2 : N_SET2;
  assign unlocked  = (cnt >= lockLimit);

  assign acc = busSel & ~anyEv;
  assign wr  = acc & busWrite;
  assign rd  = acc & ~busWrite;

  always_comb begin
    stb          = '0;
    stb.initKind = evKind;
    stb.wrCtrl   = wr & (busAddr == 3'd0) & unlocked;
    stb.wrMask   = wr & (busAddr == 3'd1) & unlocked;
    stb.wrScroll = wr & (busAddr == 3'd5) & unlocked;
    stb.wrAddr   = wr & (busAddr == 3'd6) & unlocked;
    stb.wrSpr    = wr & (busAddr == 3'd3);
    stb.incSpr   = wr & (busAddr == 3'd4);
    stb.wrData   = wr & (busAddr == 3'(REG_DATA));
    stb.rdData   = rd & (busAddr == 3'(REG_DATA));
    stb.rdStatus = rd & (busAddr == 3'(REG_STATUS));
    stb.setVbl   = ~anyEv & ((cnt == set1) | (cnt == set2));
    stb.dmaGo    = dmaTrig & ~anyEv;
  end

  // R11: the counter steps by one until its top, then stays there.
  p_cnt_step_r11: assert property (@(posedge clk) disable iff (anyEv)
    (cnt != CNT_TOP) |=> (cnt == $past(cnt) + 1'b1));
  p_cnt_hold_r11: assert property (@(posedge clk) disable iff (anyEv)
    (cnt == CNT_TOP) |=> (cnt == CNT_TOP));

endmodule

// File: rtl/vid_boot_dpath.sv
module vid_boot_dpath
  import vid_boot_pkg::*;
#(
  parameter logic [7:0]  QUICK_SPR  = 8'h2F,
  parameter logic [15:0] QUICK_ADDR = 16'h0001,
  parameter logic [7:0]  LFSR_SEED  = 8'hB7
) (
  input  logic        clk,
  input  strobe_t     stb,
  input  logic [2:0]  busAddr,
  input  logic [7:0]  busWData,
  input  logic [7:0]  vramRData,
  output logic [7:0]  busRData,
  output logic        dmaStart,
  output logic [7:0]  ctrlReg,
  output logic [7:0]  maskReg,
  output logic [15:0] scrollReg,
  output logic [15:0] vramAddr,
  output logic [7:0]  sprAddr
);
  logic        toggle;
  logic        vblFlag;
  logic [7:0]  readBuf;
  logic [7:0]  noise;
  logic [15:0] addrStep;

  vid_boot_lfsr #(.SEED(LFSR_SEED)) u_noise (
    .clk   (clk),
    .value (noise)
  );

  assign addrStep = ctrlReg[2] ? 16'd32 : 16'd1;

  always_ff @(posedge clk) begin
    dmaStart <= stb.dmaGo;
    case (stb.initKind)
      EV_POWER: begin
        ctrlReg   <= '0;
        maskReg   <= '0;
        scrollReg <= '0;
        toggle    <= 1'b0;
        vramAddr  <= '0;
        sprAddr   <= '0;
        vblFlag   <= 1'b0;
        readBuf   <= noise;
      end
      EV_QUICK: begin
        ctrlReg   <= '0;
        maskReg   <= '0;
        scrollReg <= '0;
        toggle    <= 1'b0;
        vramAddr  <= QUICK_ADDR;
        sprAddr   <= QUICK_SPR;
        vblFlag   <= 1'b1;
        readBuf   <= '0;
      end
      EV_WARM: begin
        ctrlReg   <= '0;
        maskReg   <= '0;
        scrollReg <= '0;
        toggle    <= 1'b0;
        readBuf   <= '0;
      end
      default: begin
        if (stb.wrCtrl) ctrlReg <= busWData;
        if (stb.wrMask) maskReg <= busWData;

        if (stb.rdStatus)                     toggle <= 1'b0;
        else if (stb.wrScroll || stb.wrAddr)  toggle <= ~toggle;

        if (stb.wrScroll) begin
          if (toggle) scrollReg[15:8] <= busWData;
          else        scrollReg[7:0]  <= busWData;
        end

        if (stb.wrAddr) begin
          if (toggle) vramAddr[7:0]  <= busWData;
          else        vramAddr[15:8] <= busWData;
        end else if (stb.wrData || stb.rdData) begin
          vramAddr <= vramAddr + addrStep;
        end

        if (stb.wrSpr)       sprAddr <= busWData;
        else if (stb.incSpr) sprAddr <= sprAddr + 8'd1;

        if (stb.setVbl)        vblFlag <= 1'b1;
        else if (stb.rdStatus) vblFlag <= 1'b0;

        if (stb.rdData) readBuf <= vramRData;
      end
    endcase
  end

  always_comb begin
    case (busAddr)
      3'(REG_STATUS): busRData = {vblFlag, 7'b0};
      3'(REG_DATA):   busRData = readBuf;
      default:        busRData = 8'h00;
    endcase
  end

  // R2: a warm reset leaves the video and sprite addresses and the flag.
  p_warm_keep_r2: assert property (@(posedge clk) disable iff (stb.initKind == EV_POWER)
    (stb.initKind == EV_WARM) |=> ($stable(vramAddr) && $stable(sprAddr) && $stable(vblFlag)));
  // R3: a short power cycle loads its own address and a set flag.
  p_quick_load_r3: assert property (@(posedge clk) disable iff (stb.initKind == EV_POWER)
    (stb.initKind == EV_QUICK) |=> (vramAddr == QUICK_ADDR && sprAddr == QUICK_SPR && vblFlag));
  // R8: the flag rises only from a threshold strobe or a short power cycle.
  p_vbl_rise_r8: assert property (@(posedge clk) disable iff (stb.initKind == EV_POWER)
    $rose(vblFlag) |-> ($past(stb.setVbl) || $past(stb.initKind == EV_QUICK)));
  // R10: a status read with no threshold strobe leaves the flag clear.
  p_vbl_clear_r10: assert property (@(posedge clk) disable iff (stb.initKind != EV_NONE)
    (stb.rdStatus && !stb.setVbl) |=> !vblFlag);

endmodule

// File: rtl/vid_boot_regs.sv
module vid_boot_regs
  import vid_boot_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          NTSC_LOCK  = 29658,
  parameter int          NTSC_VBL1  = 27384,
  parameter int          NTSC_FRAME = 29781,
  parameter int          PAL_LOCK   = 33132,
  parameter int          PAL_VBL1   = 25683,
  parameter int          PAL_FRAME  = 33248,
  parameter logic [7:0]  QUICK_SPR  = 8'h2F,
  parameter logic [15:0] QUICK_ADDR = 16'h0001,
  parameter logic [7:0]  LFSR_SEED  = 8'hB7
) (
  input  logic        clk,
  input  logic        powerOn,
  input  logic        warmReset,
  input  logic        quickCycle,
  input  logic        palMode,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [2:0]  busAddr,
  input  logic [7:0]  busWData,
  output logic [7:0]  busRData,
  input  logic [7:0]  vramRData,
  input  logic        dmaTrig,
  output logic        dmaStart,
  output logic [7:0]  ctrlReg,
  output logic [7:0]  maskReg,
  output logic [15:0] scrollReg,
  output logic [15:0] vramAddr,
  output logic [7:0]  sprAddr
);
  strobe_t stb;
  logic    unlocked;
  logic    anyEv;

  assign anyEv = powerOn | warmReset | quickCycle;

  vid_boot_ctrl #(
    .CNT_W(CNT_W), .NTSC_LOCK(NTSC_LOCK), .NTSC_VBL1(NTSC_VBL1), .NTSC_FRAME(NTSC_FRAME),
    .PAL_LOCK(PAL_LOCK), .PAL_VBL1(PAL_VBL1), .PAL_FRAME(PAL_FRAME)
  ) u_ctrl (
    .clk(clk), .powerOn(powerOn), .warmReset(warmReset), .quickCycle(quickCycle),
    .palMode(palMode), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .dmaTrig(dmaTrig), .stb(stb), .unlocked(unlocked)
  );

  vid_boot_dpath #(
    .QUICK_SPR(QUICK_SPR), .QUICK_ADDR(QUICK_ADDR), .LFSR_SEED(LFSR_SEED)
  ) u_dpath (
    .clk(clk), .stb(stb), .busAddr(busAddr), .busWData(busWData), .vramRData(vramRData),
    .busRData(busRData), .dmaStart(dmaStart), .ctrlReg(ctrlReg), .maskReg(maskReg),
    .scrollReg(scrollReg), .vramAddr(vramAddr), .sprAddr(sprAddr)
  );

  // R4: a locked control write leaves the control register unchanged.
  p_lock_ctrl_r4: assert property (@(posedge clk) disable iff (anyEv)
    (busSel && busWrite && busAddr == 3'd0 && !unlocked) |=> $stable(ctrlReg));
  // R5: the same holds for the scroll offset in either timing mode.
  p_lock_scroll_r5: assert property (@(posedge clk) disable iff (anyEv)
    (busSel && busWrite && busAddr == 3'd5 && !unlocked) |=> $stable(scrollReg));
  // R14: a DMA request gives a start pulse on the next cycle.
  p_dma_pulse_r14: assert property (@(posedge clk) disable iff (anyEv)
    dmaTrig |=> dmaStart);

endmodule

// File: tb/tb_vid_boot_regs.sv
module tb_vid_boot_regs;
  logic        clk = 1'b0;
  logic        powerOn = 1'b1, warmReset = 1'b0, quickCycle = 1'b0, palMode = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [7:0]  busWData = 8'h00, vramRData = 8'h00;
  logic        dmaTrig = 1'b0;
  logic [7:0]  busRData, ctrlReg, maskReg, sprAddr;
  logic [15:0] scrollReg, vramAddr;
  logic        dmaStart;

  int nChecks = 0;
  int nFails  = 0;
  int elapsed = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  vid_boot_regs dut (
    .clk(clk), .powerOn(powerOn), .warmReset(warmReset), .quickCycle(quickCycle),
    .palMode(palMode), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .vramRData(vramRData), .dmaTrig(dmaTrig),
    .dmaStart(dmaStart), .ctrlReg(ctrlReg), .maskReg(maskReg), .scrollReg(scrollReg),
    .vramAddr(vramAddr), .sprAddr(sprAddr)
  );

  // 4 time units per period: 250 MHz with a 1 ns unit.
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    elapsed++;
  endtask

  task automatic waitUntil(input int n);
    while (elapsed < n) tick();
  endtask

  // Combinational look at the read mux with no access strobe.
  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    busAddr = a;
    #0.5;
    v = busRData;
  endtask

  task automatic busWr(input logic [2:0] a, input logic [7:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWData = d;
    tick();
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    tick();
    busSel = 1'b0;
  endtask

  task automatic raiseEvent(input int which, input logic pal);
    palMode = pal;
    powerOn = (which == 0); warmReset = (which == 1); quickCycle = (which == 2);
    tick(); tick();
    powerOn = 1'b0; warmReset = 1'b0; quickCycle = 1'b0;
    elapsed = 0;
  endtask

  task automatic testNtscRun();
    logic [7:0] v;
    raiseEvent(0, 1'b0);
    check("R1", "ctrl", ctrlReg, 0);
    check("R1", "mask", maskReg, 0);
    check("R1", "scroll", scrollReg, 0);
    check("R1", "vaddr", vramAddr, 0);
    check("R1", "spr", sprAddr, 0);
    peek(3'd2, v); check("R1", "status", v, 8'h00);
    peek(3'd7, v); check("R1", "readbuf nonzero", (v != 0), 1);
    // R6 and R13: sprite offsets work at once.
    busWr(3'd3, 8'h10); check("R13", "spr load", sprAddr, 8'h10);
    busWr(3'd4, 8'hAA); check("R13", "spr inc", sprAddr, 8'h11);
    dmaTrig = 1'b1; tick(); dmaTrig = 1'b0;
    check("R14", "dma pulse", dmaStart, 1);
    tick(); check("R14", "dma end", dmaStart, 0);
    // R4: early writes dropped.
    busWr(3'd0, 8'h04); check("R4", "early ctrl", ctrlReg, 0);
    busWr(3'd1, 8'h1E); check("R4", "early mask", maskReg, 0);
    busWr(3'd5, 8'h33); check("R4", "early scroll", scrollReg, 0);
    busWr(3'd6, 8'h21); check("R4", "early vaddr", vramAddr, 0);
    waitUntil(27383);
    peek(3'd2, v); check("R8", "flag before first", v, 8'h00);
    tick();
    peek(3'd2, v); check("R8", "flag at first", v, 8'h80);
    waitUntil(29657);
    busWr(3'd0, 8'h04); check("R4", "ctrl one short", ctrlReg, 0);
    busWr(3'd0, 8'h04); check("R4", "ctrl at limit", ctrlReg, 8'h04);
    busRd(3'd2);
    peek(3'd2, v); check("R10", "flag cleared", v, 8'h00);
    busWr(3'd6, 8'h21); busWr(3'd6, 8'h08); check("R7", "vaddr pair", vramAddr, 16'h2108);
    busWr(3'd5, 8'h7D); busWr(3'd5, 8'h5E); check("R7", "scroll pair", scrollReg, 16'h5E7D);
    busWr(3'd6, 8'h3F); busRd(3'd2);
    busWr(3'd6, 8'h12); busWr(3'd6, 8'h34); check("R7", "toggle cleared by status", vramAddr, 16'h1234);
    vramRData = 8'hA5;
    busRd(3'd7);
    check("R12", "step 32", vramAddr, 16'h1254);
    peek(3'd7, v); check("R12", "buffer load", v, 8'hA5);
    busWr(3'd0, 8'h00);
    busWr(3'd7, 8'h99); check("R12", "step 1", vramAddr, 16'h1255);
    peek(3'd0, v); check("R12", "write-only reads 0", v, 8'h00);
    waitUntil(57164);
    peek(3'd2, v); check("R8", "flag before second", v, 8'h00);
    tick();
    peek(3'd2, v); check("R8", "flag at second", v, 8'h80);
    busRd(3'd2);
    waitUntil(elapsed + 3000);
    peek(3'd2, v); check("R11", "no third flag", v, 8'h00);
  endtask

  task automatic testResets();
    logic [7:0] v;
    busWr(3'd0, 8'h80); busWr(3'd1, 8'h1E);
    raiseEvent(1, 1'b0);
    check("R2", "ctrl", ctrlReg, 0);
    check("R2", "mask", maskReg, 0);
    check("R2", "scroll", scrollReg, 0);
    check("R2", "vaddr kept", vramAddr, 16'h1255);
    check("R2", "spr kept", sprAddr, 8'h11);
    peek(3'd7, v); check("R2", "readbuf", v, 8'h00);
    busWr(3'd0, 8'h55); check("R4", "warm lock", ctrlReg, 0);
    raiseEvent(2, 1'b0);
    peek(3'd2, v); check("R3", "status", v, 8'h80);
    check("R3", "spr", sprAddr, 8'h2F);
    check("R3", "vaddr", vramAddr, 16'h0001);
    check("R3", "ctrl", ctrlReg, 0);
    peek(3'd7, v); check("R3", "readbuf", v, 8'h00);
    busWr(3'd6, 8'h55); check("R4", "quick lock", vramAddr, 16'h0001);
    busWr(3'd3, 8'h44);
    raiseEvent(1, 1'b0);
    peek(3'd2, v); check("R2", "flag kept", v, 8'h80);
    check("R2", "vaddr kept quick", vramAddr, 16'h0001);
    check("R2", "spr kept quick", sprAddr, 8'h44);
  endtask

  task automatic testPalRun();
    logic [7:0] v;
    raiseEvent(0, 1'b1);
    peek(3'd7, v); check("R1", "pal readbuf nonzero", (v != 0), 1);
    vramRData = 8'h3C;
    busRd(3'd7);
    peek(3'd7, v); check("R6", "data read at once", v, 8'h3C);
    check("R6", "data step at once", vramAddr, 16'h0001);
    waitUntil(25682);
    peek(3'd2, v); check("R9", "flag before first", v, 8'h00);
    tick();
    peek(3'd2, v); check("R9", "flag at first", v, 8'h80);
    waitUntil(29658);
    busWr(3'd1, 8'h18); check("R5", "ntsc limit still locked", maskReg, 0);
    waitUntil(33131);
    busWr(3'd1, 8'h18); check("R5", "mask one short", maskReg, 0);
    busWr(3'd1, 8'h18); check("R5", "mask at limit", maskReg, 8'h18);
    busRd(3'd2);
    waitUntil(58930);
    peek(3'd2, v); check("R9", "flag before second", v, 8'h00);
    tick();
    peek(3'd2, v); check("R9", "flag at second", v, 8'h80);
  endtask

  initial begin
    testNtscRun();
    testResets();
    testPalRun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      nFails++;
      $display("FAIL watchdog run actual=%0d cycles expected=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule